// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block sits on a two-wire serial bus as a 7-bit-address slave and gives an external host byte-wide access to the chip's internal register space. A strap input chooses between two fixed device addresses, so two parts can share one bus. The block is only ever a target. It never drives the clock line, and it pulls the data line low only to acknowledge or to return read data.

Both bus lines pass through synchronizers and are oversampled by the chip clock, which must run at least eight times faster than the bus clock. After START, the block receives the device byte and compares it with its own address. On a write, the next byte becomes the internal register pointer, and every later byte is written through a one-cycle strobe while the pointer steps forward. On a read, data comes from the pointer that was latched last, one register per byte, until the host declines a byte.

Top module: `i2c_reg_slave`

## Requirements
- R1: A STOP (data rising while clock is high) returns the block to idle and releases the data line. Bits clocked after it without a new START get no acknowledge and cause no register access.
- R2: The first byte after START is taken MSB first as a 7-bit device address and a direction bit (1 = read). The address 0x18 (bytes 0x30/0x31) matches when `addr_sel` = 0, and 0x19 (bytes 0x32/0x33) matches when `addr_sel` = 1. On a match, `sda_oe` is high during the 9th clock.
- R3: A device byte that does not match gets no acknowledge, and the rest of that transfer causes no write strobe and no acknowledge.
- R4: In a write, the byte after the device byte is latched as the register pointer and is acknowledged.
- R5: Every later write byte is acknowledged and produces exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte. The pointer then increments and wraps from 0xFF to 0x00.
- R6: A read returns bytes MSB first, starting at the last latched pointer. Each byte comes from one single-cycle `reg_rd_en` pulse, with `reg_rdata` sampled in that same cycle, and the pointer increments after each byte. Write and read strobes never coincide.
- R7: After the host NACKs a read byte, the block releases the data line and makes no further read strobe. It stays released for any clocks that follow, until the next START.
- R8: A START inside a byte aborts that byte without any write, releases the data line, and restarts address matching.
- R9: After reset, `sda_oe`, `reg_wr_en` and `reg_rd_en` are low and the pointer is 0x00.
- R10: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap that selects the device address |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | ADDR_W | Register address for either strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the cycle of `reg_rd_en` |

## Verification
The assertions assume that data changes only while the clock is low, except at START and STOP. They also assume that each clock phase lasts many more chip cycles than the synchronizer delay. The check that `sda_oe` changes only with the clock low, and the checks that strobes last one cycle, depend on those assumptions. The bench holds each half period of the bus clock for 24 chip cycles and changes the data line a quarter period after each clock fall. It models the line as open drain, so the slave's pull-down and the host's drive combine as they would on a real bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_SUB,
        ST_WR,
        ST_ACK,
        ST_TX,
        ST_RACK
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    // idle bus level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.scl = scl_s;
        p_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{scl: 1'b1, sda: 1'b1};
        else        p_q <= p_d;
    end

    assign scl_rise  = scl_s & ~p_q.scl;
    assign scl_fall  = ~scl_s & p_q.scl;
    assign start_evt = scl_s & p_q.scl & p_q.sda & ~sda_s;
    assign stop_evt  = scl_s & p_q.scl & ~p_q.sda & sda_s;
endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
    import i2c_slv_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [6:0]  DEV_ADDR_LO = 7'h18,
    parameter logic [6:0]  DEV_ADDR_HI = 7'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata
);
    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] ONE  = BIT_CNT_W'(1);
    localparam logic [ADDR_W-1:0]    INC  = ADDR_W'(1);

    typedef struct packed {
        slv_state_e           st;
        slv_state_e           nxt;
        logic [BIT_CNT_W-1:0] cnt;
        logic [BYTE_W-1:0]    sh;
        logic [ADDR_W-1:0]    ptr;
        logic [ADDR_W-1:0]    addr;
        logic [BYTE_W-1:0]    wdata;
        logic                 oe;
        logic                 wr;
        logic                 rd;
        logic                 mack;
    } ctrl_t;

    ctrl_t d, q;
    logic [6:0] own_addr;

    assign own_addr = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        d.rd = 1'b0;
        if (start_evt) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_evt) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_SUB, ST_WR: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + ONE;
                    end
                    if (scl_fall && q.cnt == FULL) begin
                        d.st = ST_ACK;
                        d.oe = 1'b1;
                        if (q.st == ST_DEV) begin
                            if (q.sh[BYTE_W-1:1] != own_addr) begin
                                d.st = ST_IDLE;
                                d.oe = 1'b0;
                            end else if (q.sh[0]) begin
                                d.nxt  = ST_TX;
                                d.rd   = 1'b1;
                                d.addr = q.ptr;
                                d.ptr  = q.ptr + INC;
                            end else begin
                                d.nxt = ST_SUB;
                            end
                        end else if (q.st == ST_SUB) begin
                            d.ptr = ADDR_W'(q.sh);
                            d.nxt = ST_WR;
                        end else begin
                            d.wr    = 1'b1;
                            d.addr  = q.ptr;
                            d.wdata = q.sh;
                            d.ptr   = q.ptr + INC;
                            d.nxt   = ST_WR;
                        end
                    end
                end
                ST_ACK: begin
                    if (q.rd) d.sh = reg_rdata;
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.st  = q.nxt;
                        d.oe  = (q.nxt == ST_TX) ? ~q.sh[BYTE_W-1] : 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) d.cnt = q.cnt + ONE;
                    if (scl_fall) begin
                        if (q.cnt == FULL) begin
                            d.oe   = 1'b0;
                            d.st   = ST_RACK;
                            d.mack = 1'b0;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (q.rd) d.sh = reg_rdata;
                    if (scl_rise) begin
                        if (!sda_s) begin
                            d.mack = 1'b1;
                            d.rd   = 1'b1;
                            d.addr = q.ptr;
                            d.ptr  = q.ptr + INC;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                    if (scl_fall && q.mack) begin
                        d.st   = ST_TX;
                        d.cnt  = '0;
                        d.oe   = ~q.sh[BYTE_W-1];
                        d.mack = 1'b0;
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.nxt   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_wr_en = q.wr;
    assign reg_rd_en = q.rd;
    assign reg_addr  = q.addr;
    assign reg_wdata = q.wdata;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR_LO = 7'h18,
    parameter logic [6:0]  DEV_ADDR_HI = 7'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, sync_lines;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_evt, stop_evt;

    assign raw_lines = {sda_in, scl_in};

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[i]),
            .q     (sync_lines[i])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    i2c_bus_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_slv_ctrl #(
        .ADDR_W      (ADDR_W),
        .DEV_ADDR_LO (DEV_ADDR_LO),
        .DEV_ADDR_HI (DEV_ADDR_HI)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic reg_rd_en,
    input logic start_evt,
    input logic stop_evt
);
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_in);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
    localparam int HP    = 24;
    localparam int QP    = 12;
    localparam int LIMIT = 150000;
    localparam int NV    = 6;
    // {addr_sel, device byte, sub-address, data, expected ack}
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 8'h30, 8'h05, 8'hA5, 1'b1},
        {1'b1, 8'h32, 8'h10, 8'h3C, 1'b1},
        {1'b0, 8'h32, 8'h11, 8'h77, 1'b0},
        {1'b1, 8'h30, 8'h12, 8'h66, 1'b0},
        {1'b0, 8'h20, 8'h13, 8'h55, 1'b0},
        {1'b0, 8'h30, 8'hC7, 8'h81, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe, reg_wr_en, reg_rd_en;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire  sda_line = sda_m & ~sda_oe;

    logic [7:0] regs [256];
    logic [7:0] log_a [64];
    logic [7:0] log_d [64];
    int wr_cnt = 0, rd_cnt = 0, oe_hi = 0, oe_bad = 0, cycles = 0;
    int compared = 0, mismatched = 0;
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    i2c_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h5A;
        end else if (reg_wr_en) begin
            regs[reg_addr] <= reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (reg_wr_en) begin
            log_a[wr_cnt % 64] = reg_addr;
            log_d[wr_cnt % 64] = reg_wdata;
            wr_cnt++;
        end
        if (reg_rd_en) rd_cnt++;
        if (sda_oe) oe_hi++;
        if (sda_oe !== oe_prev && scl_m) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == LIMIT) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(QP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(QP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(QP);
        scl_m = 1'b1; tick(HP);
        scl_m = 1'b0; tick(QP);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(QP);
        scl_m = 1'b1; tick(HP/2);
        ack = (sda_line == 1'b0);
        tick(HP/2);
        scl_m = 1'b0; tick(QP);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] data);
        data = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(QP);
            scl_m = 1'b1; tick(HP/2);
            data = {data[6:0], sda_line};
            tick(HP/2);
            scl_m = 1'b0; tick(QP);
        end
        send_bit(nack);
        sda_m = 1'b1;
    endtask

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         w0, r0;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R9: idle outputs after reset
        chk("R9 sda_oe", 32'(sda_oe), 0);
        chk("R9 wr_en", 32'(reg_wr_en), 0);
        chk("R9 rd_en", 32'(reg_rd_en), 0);

        // R9/R6: read with no pointer set starts at 0x00
        bus_start();
        write_byte(8'h31, ack);
        chk("R2 read ack", 32'(ack), 1);
        read_byte(1'b1, rb);
        chk("R9 pointer zero read", 32'(rb), 32'h5A);
        bus_stop();

        // R2 R3 R4 R5: vector table of single-byte writes
        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            e = VEC[v];
            addr_sel = e[25];
            w0 = wr_cnt;
            bus_start();
            write_byte(e[24:17], ack);
            chk("R2/R3 device ack", 32'(ack), 32'(e[0]));
            write_byte(e[16:9], ack);
            chk("R4/R3 sub ack", 32'(ack), 32'(e[0]));
            write_byte(e[8:1], ack);
            chk("R5/R3 data ack", 32'(ack), 32'(e[0]));
            bus_stop();
            chk("R5/R3 write count", 32'(wr_cnt - w0), e[0] ? 1 : 0);
            if (e[0]) begin
                chk("R5 write addr", 32'(log_a[w0 % 64]), 32'(e[16:9]));
                chk("R5 write data", 32'(log_d[w0 % 64]), 32'(e[8:1]));
            end
        end
        addr_sel = 1'b0;

        // R5: multi-byte write with pointer wrap
        w0 = wr_cnt;
        bus_start();
        write_byte(8'h30, ack);
        write_byte(8'hFE, ack);
        write_byte(8'h11, ack);
        write_byte(8'h22, ack);
        write_byte(8'h33, ack);
        chk("R5 last byte ack", 32'(ack), 1);
        bus_stop();
        chk("R5 burst count", 32'(wr_cnt - w0), 3);
        chk("R5 burst addr0", 32'(log_a[w0 % 64]), 32'hFE);
        chk("R5 burst addr2 wrap", 32'(log_a[(w0 + 2) % 64]), 32'h00);
        chk("R5 burst data2", 32'(log_d[(w0 + 2) % 64]), 32'h33);

        // R6 R7: read from latched pointer with auto increment, then NACK
        r0 = rd_cnt;
        bus_start();
        write_byte(8'h30, ack);
        write_byte(8'h40, ack);
        bus_start();
        write_byte(8'h31, ack);
        chk("R6 read device ack", 32'(ack), 1);
        read_byte(1'b0, rb);
        chk("R6 read byte0", 32'(rb), 32'h1A);
        read_byte(1'b0, rb);
        chk("R6 read byte1", 32'(rb), 32'h1B);
        read_byte(1'b1, rb);
        chk("R6 read byte2", 32'(rb), 32'h18);
        oe_hi = 0;
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        chk("R7 released after nack", 32'(oe_hi), 0);
        chk("R7 read strobes", 32'(rd_cnt - r0), 3);
        bus_stop();

        // R6: read across the wrap point
        bus_start();
        write_byte(8'h30, ack);
        write_byte(8'hFF, ack);
        bus_start();
        write_byte(8'h31, ack);
        read_byte(1'b0, rb);
        chk("R6 wrap byte0", 32'(rb), 32'h22);
        read_byte(1'b1, rb);
        chk("R6 wrap byte1", 32'(rb), 32'h33);
        bus_stop();

        // R8: START inside a data byte aborts it
        w0 = wr_cnt;
        bus_start();
        write_byte(8'h30, ack);
        write_byte(8'h20, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        chk("R8 released on start", 32'(sda_oe), 0);
        write_byte(8'h30, ack);
        chk("R8 rematch ack", 32'(ack), 1);
        write_byte(8'h21, ack);
        write_byte(8'h99, ack);
        bus_stop();
        chk("R8 write count", 32'(wr_cnt - w0), 1);
        chk("R8 write addr", 32'(log_a[w0 % 64]), 32'h21);
        chk("R8 write data", 32'(log_d[w0 % 64]), 32'h99);

        // R1: bytes after STOP without START are ignored
        w0 = wr_cnt;
        oe_hi = 0;
        write_byte(8'h30, ack);
        chk("R1 no ack after stop", 32'(ack), 0);
        write_byte(8'h50, ack);
        write_byte(8'h12, ack);
        chk("R1 no writes", 32'(wr_cnt - w0), 0);
        chk("R1 line released", 32'(oe_hi), 0);

        // R10: data line drive changed only with clock low
        chk("R10 oe change while scl high", 32'(oe_bad), 0);

        summary();
        $finish;
    end
endmodule